// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register file for a board-level system controller. It sits behind a simple single-cycle request port (valid, write-enable, 20-bit byte offset, 32-bit data). It holds an LED register, a break register and a general-purpose output register, each 8 bits wide. It also holds four registers that drive a bit-banged I2C link to an attached serial EEPROM responder: input, output-enable, output and select.

A write to the I2C output register stores the value. In the same cycle it sends a one-cycle update strobe to the responder, with clock and data levels taken from the written word. A read of the I2C input register returns the stored input bits, except that bit 0 carries the responder's live data line. Software can therefore drive clock and data edges and sample the responder one register access at a time. Read data is registered and appears, with a valid flag, on the cycle after the request.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset the registers hold LED 0x00, break 0x0A, general output 0x00, I2C input 0x3, I2C output-enable 0x0, I2C output 0x3 and I2C select 0x1.
- R2: The LED register is at offset 0x408. A write keeps bits 7:0 and a read returns them zero-extended.
- R3: The break register is at offset 0x410. A write keeps bits 7:0 and a read returns them zero-extended.
- R4: The general output register is at offset 0xA00. A write keeps bits 7:0 and a read returns them zero-extended.
- R5: A read of offset 0xB00 returns the stored I2C input value (reset 0x3) with bit 0 replaced by `resp_sda` as sampled in the request cycle. Writes to 0xB00 change nothing.
- R6: The I2C output-enable register is at offset 0xB08. It stores and returns all 32 bits.
- R7: The I2C output register is at offset 0xB10. It stores and returns all 32 bits. In the cycle of the write, `i2c_strobe` is 1, `i2c_scl` equals write bit 1 and `i2c_sda` equals write bit 0.
- R8: `i2c_strobe` is 0 in every cycle that does not carry a write to 0xB10.
- R9: The I2C select register is at offset 0xB18. A write keeps bit 0 and a read returns it zero-extended.
- R10: A read of any other offset returns 0, and a write to it changes no register.
- R11: `rsp_valid` is 1 in exactly the cycle after each read request and 0 otherwise. `rsp_rdata` is updated only by reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 20 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| resp_sda | input | 1 | Data line driven by the EEPROM responder |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Registered read data |
| i2c_strobe | output | 1 | One-cycle update strobe to the responder |
| i2c_scl | output | 1 | Clock level sent with the strobe |
| i2c_sda | output | 1 | Data level sent with the strobe |

## Verification
The assertions check four things on every cycle. The strobe appears only with a write to the I2C output offset. Read responses follow their requests by exactly one cycle. Narrow registers never return bits above their width. Undecoded reads return zero and bit 0 of an input read follows the sampled responder line. Only the bench's scenarios can show the rest: stored values surviving later traffic, writes to the input and undecoded offsets leaving every register untouched, and clock/data sequences producing the expected responder level on read-back.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    parameter int BCR_AW = 20;
    parameter int BCR_DW = 32;
    parameter int BCR_NW = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BRK,
        SEL_GPOUT,
        SEL_I2CIN,
        SEL_I2COE,
        SEL_I2COUT,
        SEL_I2CSEL
    } bcr_sel_e;

    localparam logic [BCR_AW-1:0] OFF_LED    = 20'h00408;
    localparam logic [BCR_AW-1:0] OFF_BRK    = 20'h00410;
    localparam logic [BCR_AW-1:0] OFF_GPOUT  = 20'h00A00;
    localparam logic [BCR_AW-1:0] OFF_I2CIN  = 20'h00B00;
    localparam logic [BCR_AW-1:0] OFF_I2COE  = 20'h00B08;
    localparam logic [BCR_AW-1:0] OFF_I2COUT = 20'h00B10;
    localparam logic [BCR_AW-1:0] OFF_I2CSEL = 20'h00B18;

    localparam logic [BCR_NW-1:0] RST_LED    = 8'h00;
    localparam logic [BCR_NW-1:0] RST_BRK    = 8'h0A;
    localparam logic [BCR_NW-1:0] RST_GPOUT  = 8'h00;
    localparam logic [BCR_DW-1:0] RST_I2CIN  = 32'h3;
    localparam logic [BCR_DW-1:0] RST_I2COE  = 32'h0;
    localparam logic [BCR_DW-1:0] RST_I2COUT = 32'h3;
    localparam logic               RST_I2CSEL = 1'b1;
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int AW = BCR_AW
) (
    input  logic [AW-1:0] offset,
    output bcr_sel_e      sel
);
    always_comb begin
        case (offset)
            OFF_LED:    sel = SEL_LED;
            OFF_BRK:    sel = SEL_BRK;
            OFF_GPOUT:  sel = SEL_GPOUT;
            OFF_I2CIN:  sel = SEL_I2CIN;
            OFF_I2COE:  sel = SEL_I2COE;
            OFF_I2COUT: sel = SEL_I2COUT;
            OFF_I2CSEL: sel = SEL_I2CSEL;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/bcr_regs.sv
module bcr_regs
    import bcr_pkg::*;
#(
    parameter int DW = BCR_DW,
    parameter int NW = BCR_NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  bcr_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic [NW-1:0] led,
    output logic [NW-1:0] brk,
    output logic [NW-1:0] gpout,
    output logic [DW-1:0] i2cin,
    output logic [DW-1:0] i2coe,
    output logic [DW-1:0] i2cout,
    output logic          i2csel
);
    typedef struct packed {
        logic [NW-1:0] led;
        logic [NW-1:0] brk;
        logic [NW-1:0] gpout;
        logic [DW-1:0] i2cin;
        logic [DW-1:0] i2coe;
        logic [DW-1:0] i2cout;
        logic          i2csel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_LED:    st_d.led    = wdata[NW-1:0];
                SEL_BRK:    st_d.brk    = wdata[NW-1:0];
                SEL_GPOUT:  st_d.gpout  = wdata[NW-1:0];
                SEL_I2COE:  st_d.i2coe  = wdata;
                SEL_I2COUT: st_d.i2cout = wdata;
                SEL_I2CSEL: st_d.i2csel = wdata[0];
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.led    <= RST_LED;
            st_q.brk    <= RST_BRK;
            st_q.gpout  <= RST_GPOUT;
            st_q.i2cin  <= RST_I2CIN;
            st_q.i2coe  <= RST_I2COE;
            st_q.i2cout <= RST_I2COUT;
            st_q.i2csel <= RST_I2CSEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign led    = st_q.led;
    assign brk    = st_q.brk;
    assign gpout  = st_q.gpout;
    assign i2cin  = st_q.i2cin;
    assign i2coe  = st_q.i2coe;
    assign i2cout = st_q.i2cout;
    assign i2csel = st_q.i2csel;
endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
    import bcr_pkg::*;
#(
    parameter int DW = BCR_DW,
    parameter int NW = BCR_NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  bcr_sel_e      sel,
    input  logic [NW-1:0] led,
    input  logic [NW-1:0] brk,
    input  logic [NW-1:0] gpout,
    input  logic [DW-1:0] i2cin,
    input  logic [DW-1:0] i2coe,
    input  logic [DW-1:0] i2cout,
    input  logic          i2csel,
    input  logic          resp_sda,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    localparam int PADW = DW - NW;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic [DW-1:0] mux;

    always_comb begin
        case (sel)
            SEL_LED:    mux = {{PADW{1'b0}}, led};
            SEL_BRK:    mux = {{PADW{1'b0}}, brk};
            SEL_GPOUT:  mux = {{PADW{1'b0}}, gpout};
            SEL_I2CIN:  mux = {i2cin[DW-1:1], resp_sda};
            SEL_I2COE:  mux = i2coe;
            SEL_I2COUT: mux = i2cout;
            SEL_I2CSEL: mux = {{(DW-1){1'b0}}, i2csel};
            default:    mux = '0;
        endcase
        rsp_d.valid = rd_en;
        rsp_d.data  = rd_en ? mux : rsp_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rvalid = rsp_q.valid;
    assign rdata  = rsp_q.data;
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int AW = BCR_AW,
    parameter int DW = BCR_DW,
    parameter int NW = BCR_NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_offset,
    input  logic [DW-1:0] req_wdata,
    input  logic          resp_sda,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          i2c_strobe,
    output logic          i2c_scl,
    output logic          i2c_sda
);
    bcr_sel_e      sel;
    logic          wr_en, rd_en;
    logic [NW-1:0] led, brk, gpout;
    logic [DW-1:0] i2cin, i2coe, i2cout;
    logic          i2csel;

    assign wr_en = req_valid & req_write;
    assign rd_en = req_valid & ~req_write;

    bcr_decode #(.AW(AW)) u_dec (
        .offset (req_offset),
        .sel    (sel)
    );

    bcr_regs #(.DW(DW), .NW(NW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (req_wdata),
        .led    (led),
        .brk    (brk),
        .gpout  (gpout),
        .i2cin  (i2cin),
        .i2coe  (i2coe),
        .i2cout (i2cout),
        .i2csel (i2csel)
    );

    bcr_rdmux #(.DW(DW), .NW(NW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .led      (led),
        .brk      (brk),
        .gpout    (gpout),
        .i2cin    (i2cin),
        .i2coe    (i2coe),
        .i2cout   (i2cout),
        .i2csel   (i2csel),
        .resp_sda (resp_sda),
        .rvalid   (rsp_valid),
        .rdata    (rsp_rdata)
    );

    assign i2c_strobe = wr_en & (sel == SEL_I2COUT);
    assign i2c_scl    = req_wdata[1];
    assign i2c_sda    = req_wdata[0];
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
    import bcr_pkg::*;
#(
    parameter int AW = BCR_AW,
    parameter int DW = BCR_DW,
    parameter int NW = BCR_NW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_offset,
    input logic          resp_sda,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic          i2c_strobe
);
    logic rd, hit_narrow, hit_any;

    assign rd = req_valid && !req_write;
    assign hit_narrow = (req_offset == OFF_LED) || (req_offset == OFF_BRK) ||
                        (req_offset == OFF_GPOUT);
    assign hit_any = hit_narrow || (req_offset == OFF_I2CIN) ||
                     (req_offset == OFF_I2COE) || (req_offset == OFF_I2COUT) ||
                     (req_offset == OFF_I2CSEL);

    AST_STROBE_ONLY_OUT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_strobe |-> (req_valid && req_write && req_offset == OFF_I2COUT)); // R8
    AST_STROBE_ON_OUT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_offset == OFF_I2COUT) |-> i2c_strobe); // R7
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rsp_valid); // R11
    AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rsp_valid); // R11
    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_narrow) |=> (rsp_rdata[DW-1:NW] == '0)); // R2
    AST_SEL_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_offset == OFF_I2CSEL) |=> (rsp_rdata[DW-1:1] == '0)); // R9
    AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit_any) |=> (rsp_rdata == '0)); // R10
    AST_IN_LIVE_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_offset == OFF_I2CIN) |=> (rsp_rdata[0] == $past(resp_sda))); // R5
endmodule

bind board_ctrl_regs bcr_checker #(.AW(AW), .DW(DW), .NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_offset (req_offset),
    .resp_sda   (resp_sda),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .i2c_strobe (i2c_strobe)
);

// File: tb/sim_board_ctrl_regs.sv
module sim_board_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_sda;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        i2c_strobe, i2c_scl, i2c_sda;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench shadow state
    logic [31:0] m_led, m_brk, m_gp, m_oe, m_out, m_sel;
    logic        m_sda;

    always #10 clk = ~clk;

    board_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata), .resp_sda(resp_sda),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .i2c_strobe(i2c_strobe),
        .i2c_scl(i2c_scl), .i2c_sda(i2c_sda)
    );

    // behavioural responder: with clock high it echoes data, with clock low it pulls low
    always_ff @(posedge clk) begin
        if (!rst_n) resp_sda <= 1'b1;
        else if (i2c_strobe) resp_sda <= i2c_scl ? i2c_sda : 1'b0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [19:0] off);
        case (off)
            20'h00408: return m_led;
            20'h00410: return m_brk;
            20'h00A00: return m_gp;
            20'h00B00: return {30'h0, 1'b1, m_sda};
            20'h00B08: return m_oe;
            20'h00B10: return m_out;
            20'h00B18: return m_sel;
            default:   return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [19:0] off);
        case (off)
            20'h00408: return "R2";
            20'h00410: return "R3";
            20'h00A00: return "R4";
            20'h00B00: return "R5";
            20'h00B08: return "R6";
            20'h00B10: return "R7";
            20'h00B18: return "R9";
            default:   return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_led = 0; m_brk = 32'h0A; m_gp = 0; m_oe = 0; m_out = 32'h3; m_sel = 1; m_sda = 1;
    endtask

    task automatic do_write(input logic [19:0] off, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_offset = off; req_wdata = d;
        #2;
        check("R8 strobe", {31'h0, i2c_strobe}, {31'h0, off == 20'h00B10});
        if (off == 20'h00B10)
            check("R7 scl/sda", {30'h0, i2c_scl, i2c_sda}, {30'h0, d[1:0]});
        case (off)
            20'h00408: m_led = {24'h0, d[7:0]};
            20'h00410: m_brk = {24'h0, d[7:0]};
            20'h00A00: m_gp  = {24'h0, d[7:0]};
            20'h00B08: m_oe  = d;
            20'h00B10: begin m_out = d; m_sda = d[1] ? d[0] : 1'b0; end
            20'h00B18: m_sel = {31'h0, d[0]};
            default: ;
        endcase
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check("R11 no rsp after write", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic do_read(input logic [19:0] off, input string req);
        logic [31:0] e;
        e = exp_read(off);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_offset = off;
        #2;
        check("R8 no strobe on read", {31'h0, i2c_strobe}, 32'h0);
        @(negedge clk);
        req_valid = 0;
        check("R11 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check(req, rsp_rdata, e);
        @(negedge clk);
        check("R11 rdata held", rsp_rdata, e);
    endtask

    task automatic read_all(input string pfx);
        do_read(20'h00408, {pfx, " R2"});
        do_read(20'h00410, {pfx, " R3"});
        do_read(20'h00A00, {pfx, " R4"});
        do_read(20'h00B00, {pfx, " R5"});
        do_read(20'h00B08, {pfx, " R6"});
        do_read(20'h00B10, {pfx, " R7"});
        do_read(20'h00B18, {pfx, " R9"});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [19:0] offs [7];
        offs = '{20'h00408, 20'h00410, 20'h00A00, 20'h00B00, 20'h00B08, 20'h00B10, 20'h00B18};
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 idle after reset", {31'h0, rsp_valid}, 32'h0);
        read_all("R1 reset");

        // directed masking
        do_write(20'h00408, 32'hFFFF_FFA5); do_read(20'h00408, "R2 mask");
        do_write(20'h00410, 32'h1234_5678); do_read(20'h00410, "R3 mask");
        do_write(20'h00A00, 32'hDEAD_BEC3); do_read(20'h00A00, "R4 mask");
        do_write(20'h00B08, 32'hCAFE_F00D); do_read(20'h00B08, "R6 full");
        do_write(20'h00B18, 32'hFFFF_FFFE); do_read(20'h00B18, "R9 bit0 clear");
        do_write(20'h00B18, 32'h0000_0003); do_read(20'h00B18, "R9 bit0 set");

        // input register is read-only; undecoded writes change nothing
        do_write(20'h00B00, 32'h0000_0000);
        do_write(20'h00404, 32'hFFFF_FFFF);
        do_write(20'h00B04, 32'hFFFF_FFFF);
        do_write(20'hFFFFF, 32'hFFFF_FFFF);
        read_all("R10 after ignored writes");
        do_read(20'h00404, "R10 undecoded");
        do_read(20'h00900, "R10 undecoded");

        // clock/data sequence: start, bits, stop
        do_write(20'h00B10, 32'h3); do_read(20'h00B00, "R5 idle high");
        do_write(20'h00B10, 32'h2); do_read(20'h00B00, "R5 sda low scl high");
        do_write(20'h00B10, 32'h0); do_read(20'h00B00, "R5 scl low");
        do_write(20'h00B10, 32'h1); do_read(20'h00B00, "R5 scl low sda high");
        do_write(20'h00B10, 32'h3); do_read(20'h00B00, "R5 bit one");
        do_write(20'h00B10, 32'hFFFF_FFFE); do_read(20'h00B10, "R7 full store");
        do_read(20'h00B00, "R5 after full word");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [19:0] off;
            logic [31:0] d;
            int pick;
            pick = int'($urandom_range(0, 8));
            if (pick < 7) off = offs[pick];
            else begin
                off = 20'($urandom);
                foreach (offs[k]) if (off == offs[k]) off = 20'h00404;
            end
            d = $urandom;
            if ($urandom_range(0, 1) == 1) do_write(off, d);
            else do_read(off, tag_of(off));
        end
        read_all("final");

        // reset again restores every value
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
        read_all("R1 re-reset");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule